// File: doc/BRIEF.md
# FIFO-Buffered Configuration Port Controller

This block sits between a 32-bit host register bus and a word-wide configuration port. The host loads outgoing words into a transmit queue and issues a start-transmit command. The block then streams the queued words to the port over a valid/ready handshake. For readback, the host writes a word count and issues a start-receive command. The block accepts exactly that many words from the port into a receive queue, and the host drains them through a data register.

Registers report the free space in the transmit queue, the fill of the receive queue, and a status word. The status word holds a done flag, fixed constant bits and port condition inputs. Four queue events are latched in an interrupt status register and combined with per-event enables and a global gate to drive one interrupt line. The default queue depths are 1024 transmit words and 256 receive words. A single readback is bounded at 4095 words.

Top module: `cfgport_ctrl`

## Requirements
- R1: Registers sit at byte offsets 0x1C (interrupt gate, bit 31), 0x20 (interrupt status), 0x28 (interrupt enable), 0x100 (transmit data, write), 0x104 (receive data, read), 0x108 (readback length), 0x10C (command), 0x110 (status), 0x114 (transmit free slots) and 0x118 (receive words held). After reset, status reads 0x1F, free slots read the transmit depth, and every other register reads 0.
- R2: Each write to 0x100 appends one word while the transmit queue has room. A write to a full queue is dropped. Free slots equal depth minus words held.
- R3: Command bit 0 starts a transmit. Every queued word then leaves on the port in arrival order, one per cycle in which both valid and ready are high. While the transmit runs, status bit 0 reads 0 and command bit 0 reads 1. Both return to idle once the queue is empty. A later refill followed by a new start continues the stream.
- R4: The readback length keeps bits 11:0 of the written value. Command bit 1 starts a readback that accepts exactly that many words. The port ready is held low while the receive queue is full. Words come out of 0x104 in arrival order. A read of 0x104 while the queue is empty leaves the queue unchanged.
- R5: A start command written while a transfer is active is ignored. If bits 0 and 1 are written together while idle, only the transmit starts.
- R6: Status bits 4:1 always read 1. Bit 5 mirrors the abort input, bit 6 is 1 while a readback is active, bit 7 mirrors the aligned input and bit 8 mirrors the error input.
- R7: Command bit 2 empties both queues. It reads back as 1 in the cycle after the write and as 0 after that.
- R8: Command bit 3 returns every register to its reset value and empties both queues. It reads back as 1 for one cycle.
- R9: Interrupt status bits latch on the rising edge of their condition: bit 0 when the transmit queue holds at least half its depth, bit 1 when the receive queue holds at least half its depth, bit 2 when the transmit queue becomes empty, bit 3 when the receive queue becomes full. Writing 1 to a status bit toggles it.
- R10: The interrupt output is high exactly when gate bit 31 is set and at least one status bit has its enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Register write strobe |
| host_re | input | 1 | Register read strobe (pops the receive queue at 0x104) |
| host_addr | input | 9 | Byte address of the register |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid in the same cycle as host_addr |
| cfg_out_data | output | 32 | Word sent to the port |
| cfg_out_valid | output | 1 | Outgoing word valid |
| cfg_out_ready | input | 1 | Port accepts the outgoing word |
| cfg_in_data | input | 32 | Readback word from the port |
| cfg_in_valid | input | 1 | Readback word valid |
| cfg_in_ready | output | 1 | Block accepts the readback word |
| port_abort | input | 1 | Abort condition from the port |
| port_aligned | input | 1 | Data-aligned condition from the port |
| port_error | input | 1 | Configuration error from the port |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that the host never raises host_we and host_re in the same cycle. They also assume that the port's valid and data change only between clock edges. The bench drives every input shortly after a rising edge and samples at the falling edge, so each handshake it logs is the one the design commits at the next edge. The interrupt sweep runs while both queues are idle, so no queue condition can rise during it. The status flags therefore change only through the toggle writes the bench makes.

// File: rtl/cfgport_pkg.sv
// Shared register offsets and interrupt bit layout for the configuration
// port controller. Assumes byte addressing of 32-bit registers.
package cfgport_pkg;
    localparam int ADDR_W = 9;
    localparam logic [ADDR_W-1:0] A_IRQ_GATE = 9'h01C;
    localparam logic [ADDR_W-1:0] A_IRQ_STAT = 9'h020;
    localparam logic [ADDR_W-1:0] A_IRQ_MASK = 9'h028;
    localparam logic [ADDR_W-1:0] A_TX_DATA  = 9'h100;
    localparam logic [ADDR_W-1:0] A_RX_DATA  = 9'h104;
    localparam logic [ADDR_W-1:0] A_RX_LEN   = 9'h108;
    localparam logic [ADDR_W-1:0] A_CMD      = 9'h10C;
    localparam logic [ADDR_W-1:0] A_STATUS   = 9'h110;
    localparam logic [ADDR_W-1:0] A_TX_FREE  = 9'h114;
    localparam logic [ADDR_W-1:0] A_RX_USED  = 9'h118;
    localparam int IRQ_N = 4;
    // Condition / status bit order: tx half, rx half, tx empty, rx full
    localparam logic [IRQ_N-1:0] IRQ_COND_AT_RESET = 4'b0100;
endpackage

// File: rtl/cfgport_fifo.sv
// Synchronous single-clock queue. Push to a full queue and pop from an
// empty queue are ignored. Flush empties it in one cycle. The head word is
// presented combinationally; its value is undefined while empty.
module cfgport_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];

    // Pointer and fill bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    // Storage write port
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end
endmodule

// File: rtl/cfgport_seq.sv
// Transfer sequencer: runs one transmit or one bounded readback at a time.
// Assumes start strobes are single-cycle. Starts while busy are dropped;
// transmit has priority over readback when both are requested.
module cfgport_seq #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             go_tx,
    input  logic             go_rx,
    input  logic [LEN_W-1:0] rx_len,
    input  logic             tx_empty,
    input  logic             out_ready,
    input  logic             in_valid,
    input  logic             rx_full,
    output logic             tx_busy,
    output logic             rx_busy,
    output logic             out_valid,
    output logic             in_ready
);
    logic [LEN_W-1:0] left;

    assign out_valid = tx_busy && !tx_empty;
    assign in_ready  = rx_busy && !rx_full && (left != '0);

    // Transfer state and remaining readback count
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            tx_busy <= 1'b0;
            rx_busy <= 1'b0;
            left    <= '0;
        end else if (!tx_busy && !rx_busy) begin
            if (go_tx) begin
                tx_busy <= 1'b1;
            end else if (go_rx) begin
                rx_busy <= 1'b1;
                left    <= rx_len;
            end
        end else begin
            if (tx_busy && tx_empty) tx_busy <= 1'b0;
            if (in_ready && in_valid) left <= left - LEN_W'(1);
            if (rx_busy && left == '0) rx_busy <= 1'b0;
        end
    end
endmodule

// File: rtl/cfgport_irq.sv
// Interrupt unit: latches rising edges of queue conditions, lets the host
// toggle latched bits, and gates the result with enables and a global gate.
module cfgport_irq
    import cfgport_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic [IRQ_N-1:0] cond,
    input  logic             tog_we,
    input  logic [IRQ_N-1:0] tog_bits,
    input  logic [IRQ_N-1:0] enable,
    input  logic             gate,
    output logic [IRQ_N-1:0] stat,
    output logic             irq
);
    logic [IRQ_N-1:0] prev;

    assign irq = gate && |(stat & enable);

    // Edge detection and toggle-on-write status
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            prev <= IRQ_COND_AT_RESET;
            stat <= '0;
        end else begin
            prev <= cond;
            stat <= (stat ^ (tog_we ? tog_bits : '0)) | (cond & ~prev);
        end
    end
endmodule

// File: rtl/cfgport_ctrl.sv
// Top of the configuration port controller: register file, both queues,
// the sequencer and the interrupt unit. Assumes host_we and host_re are
// never high together; reads return data in the same cycle.
module cfgport_ctrl
    import cfgport_pkg::*;
#(
    parameter int WDEPTH = 1024,
    parameter int RDEPTH = 256,
    parameter int LEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic              host_re,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic [31:0]       cfg_out_data,
    output logic              cfg_out_valid,
    input  logic              cfg_out_ready,
    input  logic [31:0]       cfg_in_data,
    input  logic              cfg_in_valid,
    output logic              cfg_in_ready,
    input  logic              port_abort,
    input  logic              port_aligned,
    input  logic              port_error,
    output logic              irq
);
    localparam int TX_CNT_W = $clog2(WDEPTH + 1);
    localparam int RX_CNT_W = $clog2(RDEPTH + 1);

    logic                gate, flush_q, sreset_q;
    logic [IRQ_N-1:0]    mask, stat, cond;
    logic [LEN_W-1:0]    len;
    logic [TX_CNT_W-1:0] tx_count;
    logic [RX_CNT_W-1:0] rx_count;
    logic [31:0]         rx_head;
    logic tx_full, tx_empty, rx_full, rx_empty, tx_busy, rx_busy;
    logic cmd_wr, soft_rst, fifo_clr;

    assign cmd_wr   = host_we && (host_addr == A_CMD);
    assign soft_rst = cmd_wr && host_wdata[3];
    assign fifo_clr = cmd_wr && host_wdata[2];

    cfgport_fifo #(.DEPTH(WDEPTH), .WIDTH(32)) u_tx_q (
        .clk(clk), .rst_n(rst_n), .flush(soft_rst || fifo_clr),
        .push(host_we && host_addr == A_TX_DATA), .push_data(host_wdata),
        .pop(cfg_out_valid && cfg_out_ready), .head(cfg_out_data),
        .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    cfgport_fifo #(.DEPTH(RDEPTH), .WIDTH(32)) u_rx_q (
        .clk(clk), .rst_n(rst_n), .flush(soft_rst || fifo_clr),
        .push(cfg_in_valid && cfg_in_ready), .push_data(cfg_in_data),
        .pop(host_re && host_addr == A_RX_DATA), .head(rx_head),
        .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    cfgport_seq #(.LEN_W(LEN_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .go_tx(cmd_wr && host_wdata[0]), .go_rx(cmd_wr && host_wdata[1]),
        .rx_len(len), .tx_empty(tx_empty), .out_ready(cfg_out_ready),
        .in_valid(cfg_in_valid), .rx_full(rx_full),
        .tx_busy(tx_busy), .rx_busy(rx_busy),
        .out_valid(cfg_out_valid), .in_ready(cfg_in_ready)
    );

    assign cond = {rx_full, tx_empty,
                   rx_count >= RX_CNT_W'(RDEPTH / 2),
                   tx_count >= TX_CNT_W'(WDEPTH / 2)};

    cfgport_irq u_irq (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cond(cond),
        .tog_we(host_we && host_addr == A_IRQ_STAT),
        .tog_bits(host_wdata[IRQ_N-1:0]), .enable(mask), .gate(gate),
        .stat(stat), .irq(irq)
    );

    // Host-writable configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            gate <= 1'b0;
            mask <= '0;
            len  <= '0;
        end else if (host_we) begin
            if (host_addr == A_IRQ_GATE) gate <= host_wdata[31];
            if (host_addr == A_IRQ_MASK) mask <= host_wdata[IRQ_N-1:0];
            if (host_addr == A_RX_LEN)   len  <= host_wdata[LEN_W-1:0];
        end
    end

    // One-cycle readable echo of the clear and reset commands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_q  <= 1'b0;
            sreset_q <= 1'b0;
        end else begin
            flush_q  <= fifo_clr;
            sreset_q <= soft_rst;
        end
    end

    // Read data selection
    always_comb begin
        case (host_addr)
            A_IRQ_GATE: host_rdata = {gate, 31'b0};
            A_IRQ_STAT: host_rdata = 32'(stat);
            A_IRQ_MASK: host_rdata = 32'(mask);
            A_RX_DATA:  host_rdata = rx_empty ? 32'b0 : rx_head;
            A_RX_LEN:   host_rdata = 32'(len);
            A_CMD:      host_rdata = {28'b0, sreset_q, flush_q, rx_busy, tx_busy};
            A_STATUS:   host_rdata = {23'b0, port_error, port_aligned, rx_busy,
                                      port_abort, 4'hF, !(tx_busy || rx_busy)};
            A_TX_FREE:  host_rdata = 32'(WDEPTH) - 32'(tx_count);
            A_RX_USED:  host_rdata = 32'(rx_count);
            default:    host_rdata = 32'b0;
        endcase
    end

    logic unused_ok;
    assign unused_ok = tx_full;
endmodule

// File: rtl/cfgport_checker.sv
// Protocol checker for cfgport_ctrl, attached by bind below.
module cfgport_checker #(
    parameter int RDEPTH = 256,
    parameter int RCNT_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_busy,
    input logic              rx_busy,
    input logic              cfg_out_valid,
    input logic              cfg_in_ready,
    input logic [RCNT_W-1:0] rx_count,
    input logic              soft_rst,
    input logic              gate,
    input logic              irq
);
    // R3: words are offered to the port only during a transmit
    a_r3_out_only_in_tx: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_out_valid |-> tx_busy);
    // R4: never accept a readback word into a full receive queue
    a_r4_no_pull_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_in_ready |-> (rx_count < RCNT_W'(RDEPTH)));
    // R5: a readback can only begin from idle
    a_r5_rx_starts_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_busy) |-> !$past(tx_busy));
    // R5: a transmit can only begin from idle
    a_r5_tx_starts_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !$past(rx_busy));
    // R8: software reset leaves the block idle with an empty receive queue
    a_r8_soft_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!tx_busy && !rx_busy && rx_count == '0));
    // R10: no interrupt without the global gate
    a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> gate);
endmodule

bind cfgport_ctrl cfgport_checker #(.RDEPTH(RDEPTH), .RCNT_W(RX_CNT_W)) u_check (
    .clk(clk), .rst_n(rst_n), .tx_busy(tx_busy), .rx_busy(rx_busy),
    .cfg_out_valid(cfg_out_valid), .cfg_in_ready(cfg_in_ready),
    .rx_count(rx_count), .soft_rst(soft_rst), .gate(gate), .irq(irq)
);

// File: tb/tb_cfgport_ctrl.sv
// Self-checking bench on a small configuration (8-word transmit queue,
// 4-word receive queue). Inputs change 1 ns after a rising edge; outputs
// are sampled at the falling edge.
module tb_cfgport_ctrl;
    import cfgport_pkg::*;
    localparam int WD = 8;
    localparam int RD = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, host_we = 1'b0, host_re = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [31:0] host_wdata = '0, host_rdata, cfg_out_data;
    logic [31:0] cfg_in_data = 32'hC0DE0000;
    logic cfg_out_valid, cfg_out_ready = 1'b0, cfg_in_valid = 1'b0, cfg_in_ready;
    logic port_abort = 1'b0, port_aligned = 1'b0, port_error = 1'b0, irq;

    cfgport_ctrl #(.WDEPTH(WD), .RDEPTH(RD), .LEN_W(12)) dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cfg_out_data(cfg_out_data), .cfg_out_valid(cfg_out_valid),
        .cfg_out_ready(cfg_out_ready), .cfg_in_data(cfg_in_data),
        .cfg_in_valid(cfg_in_valid), .cfg_in_ready(cfg_in_ready),
        .port_abort(port_abort), .port_aligned(port_aligned),
        .port_error(port_error), .irq(irq)
    );

    int n_chk = 0, n_bad = 0;
    int sink_mode = 0;
    int n_sent = 0;
    logic [31:0] sent [64];
    int src_idx = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        step();
        host_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        host_re = 1'b1; host_addr = a;
        @(negedge clk);
        d = host_rdata;
        step();
        host_re = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        logic [31:0] d = 32'h0;
        for (int i = 0; i < 300; i++) begin
            bus_rd(A_STATUS, d);
            if (d[0]) break;
        end
        chk(tag, 32'(d[0]), 32'h1);
    endtask

    task automatic clear_stat();
        logic [31:0] d;
        bus_rd(A_IRQ_STAT, d);
        bus_wr(A_IRQ_STAT, d);
    endtask

    // Port sink: log each accepted outgoing word
    initial forever begin
        @(negedge clk);
        if (cfg_out_valid && cfg_out_ready) begin
            if (n_sent < 64) sent[n_sent] = cfg_out_data;
            n_sent++;
        end
    end

    // Port sink ready pattern: 0 hold, 1 always, 2 alternate
    initial forever begin
        step();
        cfg_out_ready = (sink_mode == 1) || (sink_mode == 2 && !cfg_out_ready);
    end

    // Port source: numbered words, next word after each acceptance
    initial forever begin
        bit acc;
        @(negedge clk);
        acc = cfg_in_valid && cfg_in_ready;
        step();
        if (acc) src_idx++;
        cfg_in_data  = 32'hC0DE0000 + 32'(src_idx);
        cfg_in_valid = 1'b1;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d, occ;
        int base, got;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset values
        bus_rd(A_STATUS, d);   chk("R1 status", d, 32'h1F);
        bus_rd(A_TX_FREE, d);  chk("R1 tx free", d, WD);
        bus_rd(A_RX_USED, d);  chk("R1 rx used", d, 0);
        bus_rd(A_CMD, d);      chk("R1 cmd", d, 0);
        bus_rd(A_IRQ_STAT, d); chk("R1 irq stat", d, 0);
        bus_rd(A_IRQ_MASK, d); chk("R1 irq mask", d, 0);
        bus_rd(A_IRQ_GATE, d); chk("R1 irq gate", d, 0);
        bus_rd(A_RX_LEN, d);   chk("R1 rx len", d, 0);

        // R2 fill past capacity, free slots after each write
        for (int k = 0; k < WD + 2; k++) begin
            bus_wr(A_TX_DATA, 32'h50000000 + 32'(k));
            bus_rd(A_TX_FREE, d);
            chk("R2 free slots", d, (k + 1 >= WD) ? 0 : 32'(WD - k - 1));
        end
        // R9 half-full edge latched, toggle clears and sets
        bus_rd(A_IRQ_STAT, d); chk("R9 tx half latched", d, 32'h1);
        bus_wr(A_IRQ_STAT, 32'h1);
        bus_rd(A_IRQ_STAT, d); chk("R9 toggle to 0", d, 32'h0);
        bus_wr(A_IRQ_STAT, 32'h1);
        bus_rd(A_IRQ_STAT, d); chk("R9 toggle to 1", d, 32'h1);
        bus_wr(A_IRQ_STAT, 32'h1);

        // R3 transmit with port stalled, then released
        sink_mode = 0;
        bus_wr(A_CMD, 32'h1);
        bus_rd(A_STATUS, d); chk("R3 busy status", d, 32'h1E);
        bus_rd(A_CMD, d);    chk("R3 cmd bit0 busy", d, 32'h1);
        bus_wr(A_CMD, 32'h2);                      // R5 start while busy
        bus_rd(A_STATUS, d); chk("R5 ignored rx start", d, 32'h1E);
        sink_mode = 1;
        wait_done("R3 transmit finishes");
        chk("R3 words sent", n_sent, WD);
        for (int i = 0; i < WD; i++)
            chk("R3 order", sent[i], 32'h50000000 + 32'(i));
        bus_rd(A_CMD, d);     chk("R3 cmd clears", d, 0);
        bus_rd(A_RX_USED, d); chk("R5 no readback ran", d, 0);
        bus_rd(A_IRQ_STAT, d); chk("R9 tx empty latched", d, 32'h4);
        clear_stat();

        // R3 continuation with alternating ready
        sink_mode = 2;
        for (int k = 0; k < 3; k++) bus_wr(A_TX_DATA, 32'h60000000 + 32'(k));
        bus_wr(A_CMD, 32'h1);
        wait_done("R3 chunk 1 done");
        for (int k = 3; k < 5; k++) bus_wr(A_TX_DATA, 32'h60000000 + 32'(k));
        bus_wr(A_CMD, 32'h1);
        wait_done("R3 chunk 2 done");
        chk("R3 total sent", n_sent, WD + 5);
        for (int i = 0; i < 5; i++)
            chk("R3 continued order", sent[WD + i], 32'h60000000 + 32'(i));

        // R5 both start bits together: transmit only
        sink_mode = 0;
        bus_wr(A_TX_DATA, 32'h70000000);
        bus_wr(A_CMD, 32'h3);
        bus_rd(A_CMD, d); chk("R5 tx priority", d, 32'h1);
        sink_mode = 1;
        wait_done("R5 tx done");
        chk("R5 sent word", sent[WD + 5], 32'h70000000);
        clear_stat();
        sink_mode = 0;

        // R4 readback length sweep
        for (int n = 0; n <= 6; n++) begin
            clear_stat();
            base = src_idx;
            bus_wr(A_RX_LEN, 32'(n));
            bus_wr(A_CMD, 32'h2);
            repeat (12) step();
            bus_rd(A_RX_USED, d); chk("R4 held while stalled", d, (n < RD) ? 32'(n) : RD);
            bus_rd(A_STATUS, d);
            chk("R6 status during readback", d, (n <= RD) ? 32'h1F : 32'h5E);
            got = 0;
            for (int g = 0; g < 200 && got < n; g++) begin
                bus_rd(A_RX_USED, occ);
                if (occ != 0) begin
                    bus_rd(A_RX_DATA, d);
                    chk("R4 data order", d, 32'hC0DE0000 + 32'(base + got));
                    got++;
                end
            end
            chk("R4 word count", got, n);
            wait_done("R4 readback done");
            if (n == RD) begin
                bus_rd(A_IRQ_STAT, d); chk("R9 rx half and full", d, 32'hA);
            end
        end
        // R4 empty read has no effect
        bus_rd(A_RX_DATA, d);
        bus_rd(A_RX_USED, d); chk("R4 empty read", d, 0);
        base = src_idx;
        bus_wr(A_RX_LEN, 32'h1);
        bus_wr(A_CMD, 32'h2);
        wait_done("R4 single done");
        bus_rd(A_RX_DATA, d); chk("R4 after empty read", d, 32'hC0DE0000 + 32'(base));
        bus_rd(A_RX_USED, d); chk("R4 drained", d, 0);
        bus_wr(A_RX_LEN, 32'h1003);
        bus_rd(A_RX_LEN, d); chk("R4 length truncation", d, 32'h3);

        // R6 port condition bits
        port_abort = 1'b1; port_error = 1'b1;
        step();
        bus_rd(A_STATUS, d); chk("R6 abort and error", d, 32'h13F);
        port_abort = 1'b0; port_error = 1'b0; port_aligned = 1'b1;
        step();
        bus_rd(A_STATUS, d); chk("R6 aligned", d, 32'h9F);
        port_aligned = 1'b0;

        // R7 clear both queues
        bus_wr(A_RX_LEN, 32'h2);
        bus_wr(A_CMD, 32'h2);
        wait_done("R7 setup readback");
        for (int k = 0; k < 5; k++) bus_wr(A_TX_DATA, 32'(k));
        bus_wr(A_CMD, 32'h4);
        bus_rd(A_CMD, d);     chk("R7 clear echo", d, 32'h4);
        bus_rd(A_CMD, d);     chk("R7 clear self-clears", d, 0);
        bus_rd(A_TX_FREE, d); chk("R7 tx emptied", d, WD);
        bus_rd(A_RX_USED, d); chk("R7 rx emptied", d, 0);

        // R8 software reset
        bus_wr(A_IRQ_GATE, 32'h80000000);
        bus_wr(A_IRQ_MASK, 32'hF);
        bus_wr(A_RX_LEN, 32'h5);
        clear_stat();
        bus_wr(A_IRQ_STAT, 32'h3);
        for (int k = 0; k < 3; k++) bus_wr(A_TX_DATA, 32'(k));
        bus_wr(A_CMD, 32'h8);
        bus_rd(A_CMD, d);      chk("R8 reset echo", d, 32'h8);
        bus_rd(A_CMD, d);      chk("R8 reset self-clears", d, 0);
        bus_rd(A_IRQ_GATE, d); chk("R8 gate", d, 0);
        bus_rd(A_IRQ_MASK, d); chk("R8 mask", d, 0);
        bus_rd(A_IRQ_STAT, d); chk("R8 stat", d, 0);
        bus_rd(A_RX_LEN, d);   chk("R8 length", d, 0);
        bus_rd(A_TX_FREE, d);  chk("R8 tx free", d, WD);
        bus_rd(A_STATUS, d);   chk("R8 status", d, 32'h1F);

        // R10 exhaustive gate x enable x status sweep
        for (int g = 0; g < 2; g++) begin
            for (int m = 0; m < 16; m++) begin
                for (int p = 0; p < 16; p++) begin
                    bus_wr(A_IRQ_GATE, 32'(g) << 31);
                    bus_wr(A_IRQ_MASK, 32'(m));
                    bus_rd(A_IRQ_STAT, d);
                    bus_wr(A_IRQ_STAT, d ^ 32'(p));
                    @(negedge clk);
                    chk("R10 irq", 32'(irq), 32'((g != 0) && ((p & m) != 0)));
                    step();
                end
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule